// File: doc/BRIEF.md
# Conditional Relative Jump Unit

This block resolves the relative branch format of a 16-bit processor. Each cycle it can accept one instruction word together with the byte address that word was fetched from and the four status flags: carry, zero, negative and overflow. It reports whether the word uses the jump format. It also reports whether the branch is taken and which address execution continues at.

A jump word carries a 3-bit condition selector and a signed offset counted in words. The offset is measured from the address that follows the jump. The unit never writes any flag. All address arithmetic wraps at the top of the 16-bit space. Results are registered and appear one clock after the request.

Top module: `jcu_unit`

## Requirements
- R1: A word whose bits 15:13 equal 3'b001 is a jump. is_jump_o is 1 for such words and 0 for every other word.
- R2: Selector (bits 12:10) 3'b000 is taken when the zero flag is 0. Selector 3'b001 is taken when the zero flag is 1.
- R3: Selector 3'b010 is taken when the carry flag is 0. Selector 3'b011 is taken when the carry flag is 1.
- R4: Selector 3'b100 is taken exactly when the negative flag is 1, whatever the other flags hold.
- R5: Selector 3'b101 is taken when negative equals overflow. Selector 3'b110 is taken when they differ.
- R6: Selector 3'b111 is taken for every flag combination.
- R7: A taken jump gives next_pc_o = pc_i + 2 + 2*sext(bits 9:0), modulo 2^16. This spans -1024 to +1022 bytes around pc_i + 2. Example: word 0x3FF3 at 0xC028 goes to 0xC010.
- R8: When the word is not a jump, or the condition is false, next_pc_o = pc_i + 2 modulo 2^16.
- R9: A non-jump word never reports taken, whatever its low bits and the flags hold.
- R10: Results appear one clock after valid_i is high, together with valid_o. After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Request present this cycle |
| instr_i | input | 16 | Instruction word |
| pc_i | input | 16 | Byte address of the instruction |
| c_i | input | 1 | Carry flag |
| z_i | input | 1 | Zero flag |
| n_i | input | 1 | Negative flag |
| v_i | input | 1 | Overflow flag |
| valid_o | output | 1 | Result present |
| is_jump_o | output | 1 | Word uses the jump format |
| taken_o | output | 1 | Branch taken |
| next_pc_o | output | 16 | Address of next instruction |

## Verification
The in-line properties watch several things on every cycle: the one-cycle result latency, the sequential address on a not-taken result, taken implying the jump format, always-taken for selector 111, and the zero-flag selectors. The bench scenarios cover the rest. They show every remaining selector against both flag values, and the negative-only selector with overflow set against it. They also exercise the extreme offsets of +511 and -512 words, target wrap at both ends of the address space, and non-jump words whose low bits look like an always-taken jump.

// File: rtl/jcu_pkg.sv
package jcu_pkg;
  typedef enum logic [2:0] {
    CC_ZCLR = 3'b000,
    CC_ZSET = 3'b001,
    CC_CCLR = 3'b010,
    CC_CSET = 3'b011,
    CC_NSET = 3'b100,
    CC_SGE  = 3'b101,
    CC_SLT  = 3'b110,
    CC_ANY  = 3'b111
  } cc_e;

  typedef struct packed {
    logic c;
    logic z;
    logic n;
    logic v;
  } flags_t;

  localparam logic [2:0] JMP_TAG = 3'b001;
endpackage

// File: rtl/jcu_decode.sv
module jcu_decode
  import jcu_pkg::*;
#(
  parameter int unsigned OFF_W = 10,
  localparam int unsigned INSTR_W = OFF_W + 6
) (
  input  logic [INSTR_W-1:0] instr_i,
  output logic               is_jump_o,
  output cc_e                cc_o,
  output logic [OFF_W-1:0]   off_o
);
  assign is_jump_o = (instr_i[OFF_W+5:OFF_W+3] == JMP_TAG);
  assign cc_o      = cc_e'(instr_i[OFF_W+2:OFF_W]);
  assign off_o     = instr_i[OFF_W-1:0];
endmodule

// File: rtl/jcu_cond.sv
module jcu_cond
  import jcu_pkg::*;
(
  input  cc_e    cc_i,
  input  flags_t flags_i,
  output logic   pass_o
);
  always_comb begin
    unique case (cc_i)
      CC_ZCLR: pass_o = ~flags_i.z;
      CC_ZSET: pass_o =  flags_i.z;
      CC_CCLR: pass_o = ~flags_i.c;
      CC_CSET: pass_o =  flags_i.c;
      CC_NSET: pass_o =  flags_i.n;  // no negative-clear counterpart
      CC_SGE:  pass_o = ~(flags_i.n ^ flags_i.v);
      CC_SLT:  pass_o =  (flags_i.n ^ flags_i.v);
      default: pass_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/jcu_target.sv
module jcu_target #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned OFF_W  = 10
) (
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [OFF_W-1:0]  off_i,
  output logic [ADDR_W-1:0] seq_pc_o,
  output logic [ADDR_W-1:0] jmp_pc_o
);
  localparam int unsigned EXT_W = ADDR_W - OFF_W - 1;
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(2);

  logic [ADDR_W-1:0] disp;

  // word offset -> byte displacement
  assign disp     = {{EXT_W{off_i[OFF_W-1]}}, off_i, 1'b0};
  assign seq_pc_o = pc_i + STEP;
  assign jmp_pc_o = seq_pc_o + disp;
endmodule

// File: rtl/jcu_unit.sv
module jcu_unit
  import jcu_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned OFF_W  = 10,
  localparam int unsigned INSTR_W = OFF_W + 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic [INSTR_W-1:0] instr_i,
  input  logic [ADDR_W-1:0]  pc_i,
  input  logic               c_i,
  input  logic               z_i,
  input  logic               n_i,
  input  logic               v_i,
  output logic               valid_o,
  output logic               is_jump_o,
  output logic               taken_o,
  output logic [ADDR_W-1:0]  next_pc_o
);
  logic              is_jump;
  cc_e               cc;
  logic [OFF_W-1:0]  off;
  logic              pass;
  logic              taken;
  logic [ADDR_W-1:0] seq_pc, jmp_pc;
  flags_t            flags;

  assign flags = '{c: c_i, z: z_i, n: n_i, v: v_i};

  jcu_decode #(.OFF_W(OFF_W)) u_dec (
    .instr_i  (instr_i),
    .is_jump_o(is_jump),
    .cc_o     (cc),
    .off_o    (off)
  );

  jcu_cond u_cond (
    .cc_i   (cc),
    .flags_i(flags),
    .pass_o (pass)
  );

  jcu_target #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_tgt (
    .pc_i    (pc_i),
    .off_i   (off),
    .seq_pc_o(seq_pc),
    .jmp_pc_o(jmp_pc)
  );

  assign taken = is_jump & pass;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      is_jump_o <= 1'b0;
      taken_o   <= 1'b0;
      next_pc_o <= '0;
    end else begin
      valid_o   <= valid_i;
      is_jump_o <= is_jump;
      taken_o   <= taken;
      next_pc_o <= taken ? jmp_pc : seq_pc;
    end
  end

  AST_RESULT_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);  // R10

  AST_SEQ_WHEN_NOT_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (taken_o || next_pc_o == $past(pc_i) + ADDR_W'(2)));  // R8

  AST_TAKEN_IMPLIES_JUMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && taken_o) |-> is_jump_o);  // R9

  AST_ANY_ALWAYS_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && instr_i[OFF_W+5:OFF_W] == 6'b001111) |=> taken_o);  // R6

  AST_ZERO_SELECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && instr_i[OFF_W+5:OFF_W+1] == 5'b00100) |=>
      (taken_o == ($past(z_i) == $past(instr_i[OFF_W]))));  // R2

  AST_EVEN_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (next_pc_o[0] == $past(pc_i[0])));  // R7
endmodule

// File: tb/jcu_unit_test.sv
module jcu_unit_test;
  typedef struct {
    logic        jmp;
    logic        tk;
    logic [15:0] npc;
    string       req;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [15:0] instr_i = '0;
  logic [15:0] pc_i = '0;
  logic        c_i = 0, z_i = 0, n_i = 0, v_i = 0;
  logic        valid_o, is_jump_o, taken_o;
  logic [15:0] next_pc_o;

  int n_cmp = 0;
  int n_bad = 0;
  item_t exp_q[$];
  bit done = 0;

  always #5 clk = ~clk;

  jcu_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .instr_i(instr_i), .pc_i(pc_i),
    .c_i(c_i), .z_i(z_i), .n_i(n_i), .v_i(v_i),
    .valid_o(valid_o), .is_jump_o(is_jump_o), .taken_o(taken_o), .next_pc_o(next_pc_o)
  );

  function automatic logic cond_ok(input logic [2:0] cc, input logic c, z, n, v);
    case (cc)
      3'd0: return !z;
      3'd1: return z;
      3'd2: return !c;
      3'd3: return c;
      3'd4: return n;
      3'd5: return n == v;
      3'd6: return n != v;
      default: return 1'b1;
    endcase
  endfunction

  task automatic drive(input logic [15:0] w, input logic [15:0] pc,
                       input logic [3:0] f, input string req);
    item_t it;
    logic [15:0] disp;
    it.jmp = (w[15:13] == 3'b001);
    it.tk  = it.jmp && cond_ok(w[12:10], f[3], f[2], f[1], f[0]);
    disp   = {{5{w[9]}}, w[9:0], 1'b0};
    it.npc = it.tk ? pc + 16'd2 + disp : pc + 16'd2;
    it.req = req;
    @(negedge clk);
    exp_q.push_back(it);
    valid_i = 1'b1; instr_i = w; pc_i = pc;
    {c_i, z_i, n_i, v_i} = f;
  endtask

  function automatic logic [15:0] jw(input logic [2:0] cc, input logic [9:0] off);
    return {3'b001, cc, off};
  endfunction

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (rst_n && valid_o) begin
        item_t it;
        if (exp_q.size() == 0) begin
          n_cmp++; n_bad++;
          $display("FAIL R10: unexpected result act=%h exp=none", next_pc_o);
        end else begin
          it = exp_q.pop_front();
          n_cmp++;
          if (is_jump_o !== it.jmp || taken_o !== it.tk || next_pc_o !== it.npc) begin
            n_bad++;
            $display("FAIL %s: act jmp=%b tk=%b pc=%h exp jmp=%b tk=%b pc=%h",
                     it.req, is_jump_o, taken_o, next_pc_o, it.jmp, it.tk, it.npc);
          end
        end
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: act=hung exp=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    n_cmp++;
    if (valid_o !== 0 || is_jump_o !== 0 || taken_o !== 0 || next_pc_o !== 0) begin
      n_bad++;
      $display("FAIL R10: reset act=%b%b%b %h exp=000 0000", valid_o, is_jump_o, taken_o, next_pc_o);
    end
    rst_n = 1'b1;
    @(negedge clk);

    drive(16'h3FF3, 16'hC028, 4'b0000, "R7");          // example -> C010
    drive(jw(3'd0, 10'd4), 16'h1000, 4'b0000, "R2");   // z=0 taken
    drive(jw(3'd0, 10'd4), 16'h1000, 4'b0100, "R2");   // z=1 not taken
    drive(jw(3'd1, 10'd4), 16'h1000, 4'b0100, "R2");
    drive(jw(3'd1, 10'd4), 16'h1000, 4'b0000, "R2");
    drive(jw(3'd2, 10'd8), 16'h2000, 4'b0000, "R3");
    drive(jw(3'd2, 10'd8), 16'h2000, 4'b1000, "R3");
    drive(jw(3'd3, 10'd8), 16'h2000, 4'b1000, "R3");
    drive(jw(3'd3, 10'd8), 16'h2000, 4'b0000, "R3");
    drive(jw(3'd4, 10'd1), 16'h3000, 4'b0010, "R4");
    drive(jw(3'd4, 10'd1), 16'h3000, 4'b0001, "R4");   // v set, n clear
    drive(jw(3'd4, 10'd1), 16'h3000, 4'b1100, "R4");
    drive(jw(3'd5, 10'h3FE), 16'h4000, 4'b0011, "R5");
    drive(jw(3'd5, 10'h3FE), 16'h4000, 4'b0010, "R5");
    drive(jw(3'd6, 10'h3FE), 16'h4000, 4'b0001, "R5");
    drive(jw(3'd6, 10'h3FE), 16'h4000, 4'b0000, "R5");
    for (int f = 0; f < 16; f++)
      drive(jw(3'd7, 10'd3), 16'h5000, 4'(f), "R6");
    drive(jw(3'd7, 10'h1FF), 16'h6000, 4'b0000, "R7");  // +511 words
    drive(jw(3'd7, 10'h200), 16'h6000, 4'b0000, "R7");  // -512 words
    drive(jw(3'd7, 10'd10), 16'hFFF0, 4'b0000, "R7");   // wrap high
    drive(jw(3'd7, 10'h3F0), 16'h0004, 4'b0000, "R7");  // wrap low
    drive(16'h4A09, 16'hFFFE, 4'b1111, "R8");           // non-jump, wrap
    drive(jw(3'd1, 10'd5), 16'hFFFE, 4'b0000, "R8");
    drive(16'h1FFF, 16'h0100, 4'b0100, "R9");
    drive(16'h5FFF, 16'h0100, 4'b1111, "R9");
    drive(16'h0000, 16'h0200, 4'b0000, "R1");
    drive(16'hFFFF, 16'h0200, 4'b0000, "R1");
    drive(16'h2000, 16'h0200, 4'b0000, "R1");
    @(negedge clk);
    valid_i = 1'b0;
    repeat (3) @(negedge clk);
    #2;
    // R10: valid_o drops after the last request
    n_cmp++;
    if (valid_o !== 0 || exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL R10: act valid=%b pending=%0d exp valid=0 pending=0", valid_o, exp_q.size());
    end
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule